// File: doc/BRIEF.md
# Row/Column Display-Memory Write Command Decoder

This block sits behind a byte-level serial slave and turns the stream of received bytes into write strobes for a character display memory arranged as rows and columns. After a start condition it checks the device address. It then follows the row, column and data bytes of the transfer and issues one registered write for each data byte. The write carries a 5-bit row, a 5-bit column, a plane select and a 9-bit data word.

The top bits of each byte pick one of three addressing styles. In random access, each data byte may be followed by a fresh row byte. In same-row access, column and data bytes alternate while the row is held. In sequential access, one column byte is followed by any number of data bytes, and the column steps by one after each of them. The ninth data bit comes from bit 5 of the column byte. In sequential mode an escape byte can also flip it in the middle of the stream, without writing anything. Bit-level serial signalling and reads are handled elsewhere.

Top module: `rowcol_wcmd_decoder`

## Requirements
- R1: After reset, `wr_en_o` is 0 and `wr_row_o`, `wr_col_o`, `wr_plane_o` and `wr_data_o` are all 0. Bytes that arrive without a preceding `start_i` produce no write.
- R2: The first byte after `start_i` is compared with the write address 0x7A. Any other value, including the read address 0x7B, makes every following byte produce no write until the next `start_i`.
- R3: Each byte after the address is classified by its top bits. bit7=1 is a row byte. bit7:6=00 is a column byte for random or same-row access. bit7:6=01 is a column byte for sequential access.
- R4: Random access: the sequence row, column(00), data writes the data at that row and column. A row byte may follow that data byte and start another write.
- R5: Same-row access: once a row is set, the pattern column(00), data may repeat any number of times. Each pattern writes at the new column and the row is kept.
- R6: Sequential access: after a column(01) byte, each data byte is written at the current column, and the column then increases by one. It wraps from 31 to 0.
- R7: A transfer may switch from random or same-row access into sequential access. Once in sequential access, every byte, including bytes with bit7=1, is treated as data until the next start or stop.
- R8: A row byte sets the row from bits 4:0 and the plane from bit 5 (0 = character code, 1 = attribute). A column byte sets the column from bits 4:0 and data bit 8 from bit 5. The written data is {bit8, data byte}.
- R9: When `page_tog_en_i` is 1, a byte of 0xFF arriving in sequential access inverts data bit 8, writes nothing and leaves the column unchanged. When `page_tog_en_i` is 0, 0xFF is written like any other data byte.
- R10: The escape of R9 works only when the current row is 0 to 14 and the plane is 0. In any other row or plane, 0xFF is written as data.
- R11: `start_i` in the middle of a transfer returns the decoder to address matching. `stop_i` returns it to idle, and after a stop, bytes produce no write.
- R12: `wr_en_o` rises in the cycle after the data byte's `byte_vld_i` and lasts exactly one cycle per data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start-condition flag |
| stop_i | input | 1 | One-cycle stop-condition flag |
| byte_i | input | 8 | Received byte |
| byte_vld_i | input | 1 | `byte_i` is valid this cycle |
| page_tog_en_i | input | 1 | Enables the 0xFF bit-8 escape in sequential access |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_row_o | output | 5 | Row of the write |
| wr_col_o | output | 5 | Column of the write |
| wr_plane_o | output | 1 | 0 = character code plane, 1 = attribute plane |
| wr_data_o | output | 9 | Data written |

## Verification
The assertions assume that `start_i`, `stop_i` and `byte_vld_i` are never high in the same cycle, and that each flag lasts a single cycle. The tasks drive exactly one of them per cycle, and each strobe is separated from the next by an idle cycle. The assertions also assume that `page_tog_en_i` does not change during a transfer. The bench therefore sets it before the start flag of each scenario and holds it until the scenario's checks are done.

// File: rtl/rowcol_wcmd_pkg.sv
package rowcol_wcmd_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_ROW     = 3'b000,
      ST_COL_C   = 3'b001,
      ST_COL_AB  = 3'b010,
      ST_DATA_C  = 3'b011,
      ST_IDLE    = 3'b100,
      ST_DATA_AB = 3'b110,
      ST_ADDR    = 3'b111
   } wst_e;

   typedef enum logic [1:0] {
      BC_ROW    = 2'd0,
      BC_COL_AB = 2'd1,
      BC_COL_C  = 2'd2
   } bcls_e;

endpackage

// File: rtl/rowcol_wcmd_classify.sv
module rowcol_wcmd_classify
   import rowcol_wcmd_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h3D,
   parameter logic [7:0] ESC_CODE = 8'hFF
) (
   input  logic [BYTE_W-1:0] byte_i,
   output bcls_e             cls_o,
   output logic              is_esc_o,
   output logic              is_wr_addr_o
);

   always_comb begin
      if (byte_i[7])       cls_o = BC_ROW;
      else if (byte_i[6])  cls_o = BC_COL_C;
      else                 cls_o = BC_COL_AB;
   end

   assign is_esc_o     = (byte_i == ESC_CODE);
   assign is_wr_addr_o = (byte_i[7:1] == DEV_ADDR) && !byte_i[0];

endmodule

// File: rtl/rowcol_wcmd_fsm.sv
module rowcol_wcmd_fsm
   import rowcol_wcmd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start_i,
   input  logic  stop_i,
   input  logic  byte_vld_i,
   input  logic  tog_en_i,
   input  bcls_e cls_i,
   input  logic  is_esc_i,
   input  logic  is_wr_addr_i,
   input  logic  paged_ok_i,
   output logic  ld_row_o,
   output logic  ld_col_o,
   output logic  wr_ab_o,
   output logic  wr_c_o,
   output logic  tog_o,
   output wst_e  state_o
);

   wst_e state_q, state_d;
   logic armed_q, armed_d;

   always_comb begin
      state_d  = state_q;
      armed_d  = armed_q;
      ld_row_o = 1'b0;
      ld_col_o = 1'b0;
      wr_ab_o  = 1'b0;
      wr_c_o   = 1'b0;
      tog_o    = 1'b0;
      if (start_i) begin
         state_d = ST_IDLE;
         armed_d = 1'b1;
      end else if (stop_i) begin
         state_d = ST_IDLE;
         armed_d = 1'b0;
      end else if (byte_vld_i) begin
         unique case (state_q)
            ST_IDLE: begin
               if (armed_q) begin
                  armed_d = 1'b0;
                  if (is_wr_addr_i) state_d = ST_ADDR;
               end
            end
            ST_ADDR: begin
               if (cls_i == BC_ROW) begin
                  ld_row_o = 1'b1;
                  state_d  = ST_ROW;
               end else begin
                  state_d  = ST_IDLE;
               end
            end
            ST_ROW, ST_DATA_AB: begin
               unique case (cls_i)
                  BC_ROW: begin
                     ld_row_o = 1'b1;
                     state_d  = ST_ROW;
                  end
                  BC_COL_AB: begin
                     ld_col_o = 1'b1;
                     state_d  = ST_COL_AB;
                  end
                  default: begin
                     ld_col_o = 1'b1;
                     state_d  = ST_COL_C;
                  end
               endcase
            end
            ST_COL_AB: begin
               wr_ab_o = 1'b1;
               state_d = ST_DATA_AB;
            end
            ST_COL_C, ST_DATA_C: begin
               state_d = ST_DATA_C;
               if (is_esc_i && tog_en_i && paged_ok_i) tog_o  = 1'b1;
               else                                    wr_c_o = 1'b1;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         armed_q <= 1'b0;
      end else begin
         state_q <= state_d;
         armed_q <= armed_d;
      end
   end

   assign state_o = state_q;

   AST_SEQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_COL_C || state_q == ST_DATA_C) && byte_vld_i && !start_i && !stop_i)
      |=> (state_q == ST_DATA_C)); // R7

   AST_ADDR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ADDR && byte_vld_i && !start_i && !stop_i && cls_i != BC_ROW)
      |=> (state_q == ST_IDLE)); // R3

   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> (state_q == ST_IDLE && !armed_q)); // R11

endmodule

// File: rtl/rowcol_wcmd_datapath.sv
module rowcol_wcmd_datapath
   import rowcol_wcmd_pkg::*;
#(
   parameter int ROW_W      = 5,
   parameter int COL_W      = 5,
   parameter int NUM_COLS   = 32,
   parameter int PAGED_ROWS = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              ld_row_i,
   input  logic              ld_col_i,
   input  logic              wr_ab_i,
   input  logic              wr_c_i,
   input  logic              tog_i,
   output logic              paged_ok_o,
   output logic              wr_en_o,
   output logic [ROW_W-1:0]  wr_row_o,
   output logic [COL_W-1:0]  wr_col_o,
   output logic              wr_plane_o,
   output logic [BYTE_W:0]   wr_data_o
);

   localparam logic [ROW_W-1:0] PAGED_LIM = ROW_W'(PAGED_ROWS);
   localparam logic [COL_W-1:0] COL_LAST  = COL_W'(NUM_COLS - 1);

   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q, col_inc;
   logic             plane_q, d8_q;

   generate
      if (NUM_COLS == (1 << COL_W)) begin : g_wrap_natural
         assign col_inc = col_q + 1'b1;
      end else begin : g_wrap_compare
         assign col_inc = (col_q == COL_LAST) ? '0 : col_q + 1'b1;
      end
   endgenerate

   assign paged_ok_o = (row_q < PAGED_LIM) && !plane_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q      <= '0;
         col_q      <= '0;
         plane_q    <= 1'b0;
         d8_q       <= 1'b0;
         wr_en_o    <= 1'b0;
         wr_row_o   <= '0;
         wr_col_o   <= '0;
         wr_plane_o <= 1'b0;
         wr_data_o  <= '0;
      end else begin
         wr_en_o <= wr_ab_i | wr_c_i;
         if (wr_ab_i | wr_c_i) begin
            wr_row_o   <= row_q;
            wr_col_o   <= col_q;
            wr_plane_o <= plane_q;
            wr_data_o  <= {d8_q, byte_i};
         end
         if (ld_row_i) begin
            row_q   <= byte_i[ROW_W-1:0];
            plane_q <= byte_i[5];
         end
         if (ld_col_i) begin
            col_q <= byte_i[COL_W-1:0];
            d8_q  <= byte_i[5];
         end
         if (wr_c_i) col_q <= col_inc;
         if (tog_i)  d8_q  <= ~d8_q;
      end
   end

   AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tog_i |=> (!wr_en_o && col_q == $past(col_q) && d8_q != $past(d8_q))); // R9

   AST_SEQ_WRCOL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_c_i |=> (wr_en_o && wr_col_o == $past(col_q))); // R6

   AST_TOG_PAGED: assert property (@(posedge clk) disable iff (!rst_n)
      tog_i |-> (row_q < PAGED_LIM && !plane_q)); // R10

endmodule

// File: rtl/rowcol_wcmd_decoder.sv
module rowcol_wcmd_decoder
   import rowcol_wcmd_pkg::*;
#(
   parameter int         ROW_W      = 5,
   parameter int         COL_W      = 5,
   parameter int         NUM_COLS   = 32,
   parameter int         PAGED_ROWS = 15,
   parameter logic [6:0] DEV_ADDR   = 7'h3D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              byte_vld_i,
   input  logic              page_tog_en_i,
   output logic              wr_en_o,
   output logic [ROW_W-1:0]  wr_row_o,
   output logic [COL_W-1:0]  wr_col_o,
   output logic              wr_plane_o,
   output logic [BYTE_W:0]   wr_data_o
);

   initial begin
      AST_PARAM_ROW: assert (ROW_W >= 1 && ROW_W <= 5)
         else $error("ROW_W must fit below the plane bit"); // R8
      AST_PARAM_COL: assert (COL_W >= 1 && COL_W <= 5)
         else $error("COL_W must fit below the bit-8 carrier"); // R8
      AST_PARAM_NCOL: assert (NUM_COLS >= 2 && NUM_COLS <= (1 << COL_W))
         else $error("NUM_COLS out of range"); // R6
      AST_PARAM_PAGE: assert (PAGED_ROWS >= 0 && PAGED_ROWS < (1 << ROW_W))
         else $error("PAGED_ROWS out of range"); // R10
   end

   bcls_e cls;
   logic  is_esc, is_wr_addr, paged_ok;
   logic  ld_row, ld_col, wr_ab, wr_c, tog;
   wst_e  st;

   rowcol_wcmd_classify #(
      .DEV_ADDR (DEV_ADDR),
      .ESC_CODE (8'hFF)
   ) u_cls (
      .byte_i       (byte_i),
      .cls_o        (cls),
      .is_esc_o     (is_esc),
      .is_wr_addr_o (is_wr_addr)
   );

   rowcol_wcmd_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .stop_i       (stop_i),
      .byte_vld_i   (byte_vld_i),
      .tog_en_i     (page_tog_en_i),
      .cls_i        (cls),
      .is_esc_i     (is_esc),
      .is_wr_addr_i (is_wr_addr),
      .paged_ok_i   (paged_ok),
      .ld_row_o     (ld_row),
      .ld_col_o     (ld_col),
      .wr_ab_o      (wr_ab),
      .wr_c_o       (wr_c),
      .tog_o        (tog),
      .state_o      (st)
   );

   rowcol_wcmd_datapath #(
      .ROW_W      (ROW_W),
      .COL_W      (COL_W),
      .NUM_COLS   (NUM_COLS),
      .PAGED_ROWS (PAGED_ROWS)
   ) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_i     (byte_i),
      .ld_row_i   (ld_row),
      .ld_col_i   (ld_col),
      .wr_ab_i    (wr_ab),
      .wr_c_i     (wr_c),
      .tog_i      (tog),
      .paged_ok_o (paged_ok),
      .wr_en_o    (wr_en_o),
      .wr_row_o   (wr_row_o),
      .wr_col_o   (wr_col_o),
      .wr_plane_o (wr_plane_o),
      .wr_data_o  (wr_data_o)
   );

   AST_WR_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> $past(byte_vld_i)); // R12

   AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> ($past(st) == ST_COL_AB || $past(st) == ST_COL_C
                   || $past(st) == ST_DATA_C)); // R4

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && byte_vld_i && !start_i && !stop_i) |=> !wr_en_o); // R2

   AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (st == ST_IDLE && !wr_en_o)); // R11

endmodule

// File: tb/rowcol_wcmd_decoder_tb.sv
module rowcol_wcmd_decoder_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0, page_tog_en_i = 1'b0;
   logic [7:0] byte_i = '0;
   logic       wr_en_o, wr_plane_o;
   logic [4:0] wr_row_o, wr_col_o;
   logic [8:0] wr_data_o;

   int n_chk = 0, n_err = 0;
   int wr_total = 0;
   logic [4:0] lg_row [0:63];
   logic [4:0] lg_col [0:63];
   logic       lg_pl  [0:63];
   logic [8:0] lg_dat [0:63];
   bit done = 0;

   always #2 clk = ~clk;

   rowcol_wcmd_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .byte_i(byte_i), .byte_vld_i(byte_vld_i), .page_tog_en_i(page_tog_en_i),
      .wr_en_o(wr_en_o), .wr_row_o(wr_row_o), .wr_col_o(wr_col_o),
      .wr_plane_o(wr_plane_o), .wr_data_o(wr_data_o)
   );

   always @(negedge clk) begin
      if (rst_n && wr_en_o) begin
         lg_row[wr_total % 64] <= wr_row_o;
         lg_col[wr_total % 64] <= wr_col_o;
         lg_pl[wr_total % 64]  <= wr_plane_o;
         lg_dat[wr_total % 64] <= wr_data_o;
         wr_total <= wr_total + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk) stop_i = 1'b1;
      @(negedge clk) stop_i = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk) begin byte_i = b; byte_vld_i = 1'b1; end
      @(negedge clk) byte_vld_i = 1'b0;
   endtask

   task automatic send_seq(input logic [7:0] q [], input bit with_start);
      if (with_start) pulse_start();
      foreach (q[i]) send(q[i]);
      repeat (2) @(negedge clk);
   endtask

   task automatic chk_wr(input int base, input int k, input int row, input int col,
                         input int pl, input int dat, input string req);
      int p;
      p = (base + k) % 64;
      chk(lg_row[p] == row[4:0], {req, " row"}, lg_row[p], row);
      chk(lg_col[p] == col[4:0], {req, " col"}, lg_col[p], col);
      chk(lg_pl[p] == pl[0],     {req, " plane"}, lg_pl[p], pl);
      chk(lg_dat[p] == dat[8:0], {req, " data"}, lg_dat[p], dat);
   endtask

   // R1: reset values and bytes without start
   task automatic t_reset();
      int base;
      chk(wr_en_o == 1'b0, "R1 reset wr_en", wr_en_o, 0);
      chk({wr_row_o, wr_col_o, wr_plane_o, wr_data_o} == '0, "R1 reset outputs",
          {wr_row_o, wr_col_o, wr_plane_o, wr_data_o}, 0);
      base = wr_total;
      send_seq('{8'h7A, 8'h81, 8'h40, 8'h55}, 1'b0);
      chk(wr_total == base, "R1 no start no write", wr_total - base, 0);
   endtask

   // R2: address mismatch and read address
   task automatic t_addr();
      int base;
      base = wr_total;
      send_seq('{8'h7C, 8'h81, 8'h40, 8'h55}, 1'b1);
      chk(wr_total == base, "R2 wrong address", wr_total - base, 0);
      send_seq('{8'h7B, 8'h81, 8'h40, 8'h55}, 1'b1);
      chk(wr_total == base, "R2 read address", wr_total - base, 0);
   endtask

   // R4 R8 R3: random access, plane and bit 8
   task automatic t_random();
      int base;
      base = wr_total;
      send_seq('{8'h7A, 8'h83, 8'h05, 8'h41, 8'hA2, 8'h3F, 8'h99}, 1'b1);
      pulse_stop();
      chk(wr_total - base == 2, "R4 write count", wr_total - base, 2);
      chk_wr(base, 0, 3, 5, 0, 'h041, "R4");
      chk_wr(base, 1, 2, 31, 1, 'h199, "R8");
   endtask

   // R5: same-row access
   task automatic t_samerow();
      int base;
      base = wr_total;
      send_seq('{8'h7A, 8'h84, 8'h02, 8'h11, 8'h07, 8'h22}, 1'b1);
      pulse_stop();
      chk(wr_total - base == 2, "R5 write count", wr_total - base, 2);
      chk_wr(base, 0, 4, 2, 0, 'h011, "R5");
      chk_wr(base, 1, 4, 7, 0, 'h022, "R5");
   endtask

   // R6: sequential with wrap 31 -> 0
   task automatic t_seq();
      int base;
      base = wr_total;
      send_seq('{8'h7A, 8'h8A, 8'h5E, 8'h01, 8'h02, 8'h03, 8'h04}, 1'b1);
      pulse_stop();
      chk(wr_total - base == 4, "R6 write count", wr_total - base, 4);
      chk_wr(base, 0, 10, 30, 0, 'h001, "R6");
      chk_wr(base, 1, 10, 31, 0, 'h002, "R6");
      chk_wr(base, 2, 10, 0, 0, 'h003, "R6 wrap");
      chk_wr(base, 3, 10, 1, 0, 'h004, "R6");
   endtask

   // R7: random into sequential, then row-looking bytes are data
   task automatic t_switch();
      int base;
      base = wr_total;
      send_seq('{8'h7A, 8'h81, 8'h03, 8'h10, 8'h45, 8'h20, 8'h90, 8'hC3}, 1'b1);
      pulse_stop();
      chk(wr_total - base == 4, "R7 write count", wr_total - base, 4);
      chk_wr(base, 0, 1, 3, 0, 'h010, "R7");
      chk_wr(base, 1, 1, 5, 0, 'h020, "R7");
      chk_wr(base, 2, 1, 6, 0, 'h090, "R7 bit7 data");
      chk_wr(base, 3, 1, 7, 0, 'h0C3, "R7 bit7 data");
   endtask

   // R9: escape toggles bit 8 when enabled, is data when disabled
   task automatic t_toggle();
      int base;
      page_tog_en_i = 1'b1;
      base = wr_total;
      send_seq('{8'h7A, 8'h81, 8'h60, 8'h58, 8'h54, 8'hFF, 8'h07, 8'h09, 8'h01, 8'h06}, 1'b1);
      pulse_stop();
      chk(wr_total - base == 6, "R9 write count", wr_total - base, 6);
      chk_wr(base, 0, 1, 0, 0, 'h158, "R9");
      chk_wr(base, 1, 1, 1, 0, 'h154, "R9");
      chk_wr(base, 2, 1, 2, 0, 'h007, "R9 toggled");
      chk_wr(base, 3, 1, 3, 0, 'h009, "R9");
      chk_wr(base, 5, 1, 5, 0, 'h006, "R9");
      page_tog_en_i = 1'b0;
      base = wr_total;
      send_seq('{8'h7A, 8'h81, 8'h60, 8'h58, 8'hFF, 8'h07}, 1'b1);
      pulse_stop();
      chk(wr_total - base == 3, "R9 disabled count", wr_total - base, 3);
      chk_wr(base, 1, 1, 1, 0, 'h1FF, "R9 disabled");
      chk_wr(base, 2, 1, 2, 0, 'h107, "R9 disabled");
   endtask

   // R10: escape inactive in row 15 and in attribute plane
   task automatic t_paged();
      int base;
      page_tog_en_i = 1'b1;
      base = wr_total;
      send_seq('{8'h7A, 8'h8F, 8'h40, 8'hFF, 8'h05}, 1'b1);
      pulse_stop();
      chk(wr_total - base == 2, "R10 row15 count", wr_total - base, 2);
      chk_wr(base, 0, 15, 0, 0, 'h0FF, "R10 row15");
      chk_wr(base, 1, 15, 1, 0, 'h005, "R10 row15");
      base = wr_total;
      send_seq('{8'h7A, 8'hA1, 8'h40, 8'hFF}, 1'b1);
      pulse_stop();
      chk(wr_total - base == 1, "R10 attr count", wr_total - base, 1);
      chk_wr(base, 0, 1, 0, 1, 'h0FF, "R10 attr");
      page_tog_en_i = 1'b0;
   endtask

   // R11: restart mid-transfer and stop
   task automatic t_restart();
      int base;
      base = wr_total;
      send_seq('{8'h7A, 8'h81, 8'h02}, 1'b1);
      send_seq('{8'h55, 8'h66, 8'h77}, 1'b1);
      chk(wr_total == base, "R11 restart bad addr", wr_total - base, 0);
      send_seq('{8'h7A, 8'h81, 8'h02}, 1'b1);
      pulse_stop();
      send_seq('{8'h33, 8'h44}, 1'b0);
      chk(wr_total == base, "R11 after stop", wr_total - base, 0);
      send_seq('{8'h7A, 8'h81, 8'h02}, 1'b1);
      send_seq('{8'h7A, 8'h85, 8'h03, 8'h44}, 1'b1);
      pulse_stop();
      chk(wr_total - base == 1, "R11 restart count", wr_total - base, 1);
      chk_wr(base, 0, 5, 3, 0, 'h044, "R11");
   endtask

   // R12: strobe one cycle after the byte, one cycle wide
   task automatic t_timing();
      send_seq('{8'h7A, 8'h86, 8'h49}, 1'b1);
      @(negedge clk) begin byte_i = 8'h33; byte_vld_i = 1'b1; end
      @(negedge clk) byte_vld_i = 1'b0;
      chk(wr_en_o == 1'b1, "R12 strobe high", wr_en_o, 1);
      chk(wr_data_o == 9'h033 && wr_col_o == 5'd9, "R12 payload", wr_data_o, 'h033);
      @(negedge clk);
      chk(wr_en_o == 1'b0, "R12 strobe width", wr_en_o, 0);
      pulse_stop();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr();
      t_random();
      t_samerow();
      t_seq();
      t_switch();
      t_toggle();
      t_paged();
      t_restart();
      t_timing();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired act=0x0 exp=0x1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule